// File: doc/BRIEF.md
# Sleep Mode Controller

This block is the power-management sequencer beside an 8-bit processor core. The core reads and writes an 8-bit control byte. Inside that byte are a sleep-enable bit and a 3-bit sleep-mode code. When the core executes its sleep instruction, it raises a one-cycle strobe. If sleep is enabled and the selected mode is allowed, the block parks the core in that mode. While parked it shows the mode on a one-hot output, which tells the surrounding clock logic which domains to gate.

The block stays asleep until one of two events arrives. An enabled interrupt starts the wake-up sequence: a start-up delay that depends on the mode, followed by a fixed four-cycle halt, after which the core may service the interrupt. A reset request instead releases the core at once and signals the reset path. Waking never clears any storage.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: The control byte resets to 0x00, is written whole when `reg_we_i` is high at a clock edge, and `reg_rdata_o` always shows its current value.
- R2: Sleep is entered only at an edge where `sleep_instr_i` is high and bit 5 (enable) of the control byte is 1. The mode code is taken from bits 4:2. A strobe while the enable bit is 0 changes no output.
- R3: The codes 000 (Idle), 001 (ADC-quiet), 010 (Power-down) and 011 (Power-save) are always allowed. Codes 100 and 101 are never allowed. Codes 110 (Standby) and 111 (Extended Standby) are allowed only while `ext_xtal_i` is 1.
- R4: An enabled strobe with a code that is not allowed leaves the block awake. It raises `entry_err_o` for exactly one cycle, the cycle after the strobe edge.
- R5: While asleep, `sleeping_o` is 1 and `mode_oh_o` has exactly one bit set. That bit is 0 for Idle, 1 for ADC-quiet, 2 for Power-down, 3 for Power-save, 4 for Standby and 5 for Extended Standby. While awake, both outputs are 0.
- R6: `cpu_stall_o` rises in the cycle after the entry edge and stays high through sleep and wake-up.
- R7: After an interrupt is sampled by `irq_i` while asleep, `cpu_stall_o` stays high for D+4 more cycles, where D is the mode's start-up parameter (Idle is always 0). `wake_done_o` is high in the last of those cycles only.
- R8: Interrupts seen during the start-up delay or the halt, or after release, do not start a second wake. Each sleep gives exactly one `wake_done_o` cycle.
- R9: `rst_req_i` high while asleep or waking returns the block to run at that edge. In the next cycle `reset_wake_o` is 1, `cpu_stall_o` is 0, and `wake_done_o` stays 0.
- R10: The control byte keeps its value across sleep and either kind of wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Control byte read data |
| sleep_instr_i | input | 1 | Sleep instruction executed (one cycle) |
| ext_xtal_i | input | 1 | External crystal or resonator in use |
| irq_i | input | 1 | Enabled interrupt pending |
| rst_req_i | input | 1 | Reset request from the reset logic |
| mode_oh_o | output | 6 | One-hot active sleep mode |
| sleeping_o | output | 1 | Asleep |
| cpu_stall_o | output | 1 | Hold the core |
| wake_done_o | output | 1 | Last stalled cycle of an interrupt wake |
| reset_wake_o | output | 1 | Sleep left by reset (one cycle) |
| entry_err_o | output | 1 | Refused sleep request (one cycle) |

## Verification
The hardest cases to reach are the events that land inside the wake-up window: a second interrupt during the start-up delay or the halt, and a reset request part way through start-up. The bench holds `irq_i` high or toggles it at random for the whole wake window, counts the stalled cycles and the `wake_done_o` cycles, and compares both with the mode's start-up parameter. In a directed case it raises `rst_req_i` a few cycles into the Power-down start-up. The random loop draws control bytes and crystal settings, which covers refused codes, including Standby without a crystal.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  localparam int RegW   = 8;
  localparam int EnBit  = 5;
  localparam int SmLsb  = 2;
  localparam int SmW    = 3;
  localparam int NModes = 6;
  localparam int HaltCyc = 4;

  typedef enum logic [SmW-1:0] {
    SM_IDLE  = 3'd0,
    SM_ADCQ  = 3'd1,
    SM_PDOWN = 3'd2,
    SM_PSAVE = 3'd3,
    SM_RSV4  = 3'd4,
    SM_RSV5  = 3'd5,
    SM_STBY  = 3'd6,
    SM_XSTBY = 3'd7
  } sm_code_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_START,
    ST_HALT
  } seq_st_e;
endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_sleep_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RegW-1:0] wdata_i,
  output logic [RegW-1:0] q_o
);
  for (genvar b = 0; b < RegW; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[b] <= 1'b0;
      else if (we_i) q_o[b] <= wdata_i[b];
    end
  end
endmodule

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
  import pwr_sleep_pkg::*;
(
  input  sm_code_e          code_i,
  input  logic              xtal_i,
  output logic              legal_o,
  output logic [NModes-1:0] oh_o
);
  always_comb begin
    oh_o    = '0;
    legal_o = 1'b1;
    unique case (code_i)
      SM_IDLE:  oh_o[0] = 1'b1;
      SM_ADCQ:  oh_o[1] = 1'b1;
      SM_PDOWN: oh_o[2] = 1'b1;
      SM_PSAVE: oh_o[3] = 1'b1;
      SM_STBY:  begin oh_o[4] = 1'b1; legal_o = xtal_i; end
      SM_XSTBY: begin oh_o[5] = 1'b1; legal_o = xtal_i; end
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned DLY_ADCQ  = 0,
  parameter int unsigned DLY_PDOWN = 16,
  parameter int unsigned DLY_PSAVE = 12,
  parameter int unsigned DLY_STBY  = 6,
  parameter int unsigned DLY_XSTBY = 6
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     se_i,
  input  sm_code_e sm_i,
  input  logic     legal_i,
  input  logic     sleep_i,
  input  logic     irq_i,
  input  logic     rst_req_i,
  output sm_code_e cur_sm_o,
  output logic     asleep_o,
  output logic     stall_o,
  output logic     wake_done_o,
  output logic     reset_wake_o,
  output logic     err_o
);
  localparam int unsigned MaxA = (DLY_PDOWN > DLY_PSAVE) ? DLY_PDOWN : DLY_PSAVE;
  localparam int unsigned MaxB = (DLY_STBY > DLY_XSTBY) ? DLY_STBY : DLY_XSTBY;
  localparam int unsigned MaxC = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int unsigned MaxD = (MaxC > DLY_ADCQ) ? MaxC : DLY_ADCQ;
  localparam int unsigned CntMax = (MaxD > HaltCyc) ? MaxD : HaltCyc;
  localparam int CW = $clog2(CntMax + 1);

  seq_st_e       st_q;
  sm_code_e      sm_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dly;

  always_comb begin
    unique case (sm_q)
      SM_ADCQ:  dly = CW'(DLY_ADCQ);
      SM_PDOWN: dly = CW'(DLY_PDOWN);
      SM_PSAVE: dly = CW'(DLY_PSAVE);
      SM_STBY:  dly = CW'(DLY_STBY);
      SM_XSTBY: dly = CW'(DLY_XSTBY);
      default:  dly = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_RUN;
      sm_q         <= SM_IDLE;
      cnt_q        <= '0;
      err_o        <= 1'b0;
      reset_wake_o <= 1'b0;
    end else begin
      err_o        <= 1'b0;
      reset_wake_o <= 1'b0;
      if (st_q != ST_RUN && rst_req_i) begin
        st_q         <= ST_RUN;
        reset_wake_o <= 1'b1;
      end else begin
        unique case (st_q)
          ST_RUN: if (sleep_i && se_i) begin
            if (legal_i) begin
              st_q <= ST_SLEEP;
              sm_q <= sm_i;
            end else begin
              err_o <= 1'b1;
            end
          end
          ST_SLEEP: if (irq_i) begin
            if (dly == '0) begin
              st_q  <= ST_HALT;
              cnt_q <= CW'(HaltCyc - 1);
            end else begin
              st_q  <= ST_START;
              cnt_q <= dly - 1'b1;
            end
          end
          ST_START: begin
            if (cnt_q == '0) begin
              st_q  <= ST_HALT;
              cnt_q <= CW'(HaltCyc - 1);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_HALT: begin
            if (cnt_q == '0) st_q <= ST_RUN;
            else             cnt_q <= cnt_q - 1'b1;
          end
          default: st_q <= ST_RUN;
        endcase
      end
    end
  end

  assign cur_sm_o    = sm_q;
  assign asleep_o    = (st_q == ST_SLEEP);
  assign stall_o     = (st_q != ST_RUN);
  assign wake_done_o = (st_q == ST_HALT) && (cnt_q == '0);

  // R2: no entry while enable is low
  a_r2_need_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && sleep_i && !se_i) |=> (st_q == ST_RUN && !err_o));
  // R4: refused request leaves the sequencer in run
  a_r4_err_stays_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (st_q == ST_RUN && $past(sleep_i)));
  // R7: halt is not cut short without a reset request
  a_r7_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALT && cnt_q != '0 && !rst_req_i) |=> (st_q == ST_HALT));
  // R8: release follows the done cycle, no re-wake
  a_r8_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !stall_o);
  // R9: reset wake never reports a done
  a_r9_reset_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_wake_o |-> (!wake_done_o && !stall_o));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned DLY_ADCQ  = 0,
  parameter int unsigned DLY_PDOWN = 16,
  parameter int unsigned DLY_PSAVE = 12,
  parameter int unsigned DLY_STBY  = 6,
  parameter int unsigned DLY_XSTBY = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RegW-1:0]   reg_wdata_i,
  output logic [RegW-1:0]   reg_rdata_o,
  input  logic              sleep_instr_i,
  input  logic              ext_xtal_i,
  input  logic              irq_i,
  input  logic              rst_req_i,
  output logic [NModes-1:0] mode_oh_o,
  output logic              sleeping_o,
  output logic              cpu_stall_o,
  output logic              wake_done_o,
  output logic              reset_wake_o,
  output logic              entry_err_o
);
  logic [RegW-1:0]   ctrl;
  sm_code_e          reg_sm, cur_sm, dec_sm;
  logic              legal, asleep;
  logic [NModes-1:0] dec_oh;

  pwr_ctrl_reg u_reg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i), .q_o(ctrl)
  );

  assign reg_sm = sm_code_e'(ctrl[SmLsb +: SmW]);
  // one decoder: register code while awake, latched code while asleep
  assign dec_sm = asleep ? cur_sm : reg_sm;

  pwr_mode_dec u_dec (
    .code_i(dec_sm), .xtal_i(ext_xtal_i), .legal_o(legal), .oh_o(dec_oh)
  );

  pwr_wake_seq #(
    .DLY_ADCQ(DLY_ADCQ), .DLY_PDOWN(DLY_PDOWN), .DLY_PSAVE(DLY_PSAVE),
    .DLY_STBY(DLY_STBY), .DLY_XSTBY(DLY_XSTBY)
  ) u_seq (
    .clk_i, .rst_ni,
    .se_i(ctrl[EnBit]), .sm_i(reg_sm), .legal_i(legal),
    .sleep_i(sleep_instr_i), .irq_i, .rst_req_i,
    .cur_sm_o(cur_sm), .asleep_o(asleep), .stall_o(cpu_stall_o),
    .wake_done_o, .reset_wake_o, .err_o(entry_err_o)
  );

  assign reg_rdata_o = ctrl;
  assign sleeping_o  = asleep;
  assign mode_oh_o   = asleep ? dec_oh : '0;

  // R5: one-hot mode exactly while sleeping
  a_r5_onehot_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_oh_o) && (sleeping_o == (mode_oh_o != '0)));
  // R6: sleeping implies the core is held
  a_r6_stall_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleeping_o |-> cpu_stall_o);
  // R10: wake leaves the control byte untouched
  a_r10_reg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wake_done_o || (cpu_stall_o && rst_req_i)) && !reg_we_i) |=> $stable(reg_rdata_o));
endmodule

// File: tb/sim_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_sleep_ctrl;
  localparam int D_ADCQ = 2, D_PDOWN = 9, D_PSAVE = 7, D_STBY = 5, D_XSTBY = 3;

  logic clk = 0, rst_n = 0;
  logic we = 0, sleep = 0, xtal = 0, irq = 0, rreq = 0;
  logic [7:0] wdata = 0, rdata;
  logic [5:0] moh;
  logic slp, stall, done, rwake, err;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwr_sleep_ctrl #(.DLY_ADCQ(D_ADCQ), .DLY_PDOWN(D_PDOWN), .DLY_PSAVE(D_PSAVE),
                   .DLY_STBY(D_STBY), .DLY_XSTBY(D_XSTBY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sleep_instr_i(sleep), .ext_xtal_i(xtal),
    .irq_i(irq), .rst_req_i(rreq), .mode_oh_o(moh), .sleeping_o(slp),
    .cpu_stall_o(stall), .wake_done_o(done), .reset_wake_o(rwake),
    .entry_err_o(err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_legal(input logic [2:0] sm, input logic x);
    return (sm != 3'd4) && (sm != 3'd5) && (sm < 3'd6 || x);
  endfunction
  function automatic int exp_oh(input logic [2:0] sm);
    case (sm)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;
      3'd3: return 8;  3'd6: return 16; 3'd7: return 32;
      default: return 0;
    endcase
  endfunction
  function automatic int exp_dly(input logic [2:0] sm);
    case (sm)
      3'd1: return D_ADCQ; 3'd2: return D_PDOWN; 3'd3: return D_PSAVE;
      3'd6: return D_STBY; 3'd7: return D_XSTBY;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1; wdata = v;
    @(negedge clk); we = 0;
    chk(rdata == v, "R1 write/read", rdata, v);
  endtask

  // returns 1 if asleep afterwards
  task automatic try_sleep(input logic [7:0] v, input logic x, output bit entered);
    bit en, lg;
    wr(v);
    xtal = x;
    sleep = 1;
    @(negedge clk); sleep = 0;
    en = v[5];
    lg = exp_legal(v[4:2], x);
    entered = en && lg;
    chk(slp == entered, "R2 entry", slp, entered);
    chk(err == (en && !lg), "R4 err pulse", err, en && !lg);
    chk(stall == entered, "R6 stall on entry", stall, entered);
    chk(moh == (entered ? exp_oh(v[4:2]) : 0), "R5 onehot", moh,
        entered ? exp_oh(v[4:2]) : 0);
    if (!entered && en) begin
      @(negedge clk);
      chk(err == 0, "R4 err one cycle", err, 0);
      chk(slp == 0, "R3 refused stays awake", slp, 0);
    end
  endtask

  task automatic irq_wake(input logic [7:0] v, input bit noisy);
    int n, d;
    d = 0;
    n = 0;
    irq = 1;
    @(negedge clk);
    if (noisy) irq = 1'($urandom);
    while (stall && n < 200) begin
      n++;
      if (done) d++;
      if (noisy) irq = 1'($urandom);
      @(negedge clk);
    end
    chk(n == exp_dly(v[4:2]) + 4, "R7 stall length", n, exp_dly(v[4:2]) + 4);
    chk(d == 1, "R8 single done", d, 1);
    irq = 1;
    @(negedge clk);
    chk(stall == 0 && slp == 0, "R8 no re-wake", stall, 0);
    irq = 0;
    chk(rdata == v, "R10 reg kept irq", rdata, v);
  endtask

  task automatic rst_wake(input logic [7:0] v, input int pre_irq);
    irq = (pre_irq > 0);
    repeat (pre_irq) @(negedge clk);
    irq = 0;
    rreq = 1;
    @(negedge clk); rreq = 0;
    chk(rwake == 1, "R9 reset wake pulse", rwake, 1);
    chk(stall == 0 && done == 0, "R9 released no done", {stall, done}, 0);
    @(negedge clk);
    chk(rwake == 0, "R9 pulse one cycle", rwake, 0);
    chk(rdata == v, "R10 reg kept reset", rdata, v);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit e;
    void'($urandom(32'h5eed_1234));
    #5;
    chk(rdata == 0 && slp == 0 && stall == 0 && moh == 0 && err == 0,
        "R1 reset state", rdata, 0);
    rst_n = 1;
    // enable off: strobe ignored
    try_sleep(8'b0000_1000, 0, e);
    // reserved codes
    try_sleep(8'b0011_0000, 1, e);
    try_sleep(8'b0011_0100, 1, e);
    // standby without crystal refused, then with crystal allowed
    try_sleep(8'b0011_1000, 0, e);
    try_sleep(8'b0011_1000, 1, e);
    if (e) irq_wake(8'b0011_1000, 0);
    // idle: zero start-up
    try_sleep(8'b1010_0011, 0, e);
    if (e) irq_wake(8'b1010_0011, 0);
    // power-down with noisy interrupt during start-up
    try_sleep(8'b0010_1000, 0, e);
    if (e) irq_wake(8'b0010_1000, 1);
    // reset while asleep, and reset part way through start-up
    try_sleep(8'b0010_1100, 0, e);
    if (e) rst_wake(8'b0010_1100, 0);
    try_sleep(8'b0110_1001, 0, e);
    if (e) rst_wake(8'b0110_1001, 3);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      try_sleep(v, 1'($urandom), e);
      if (e) begin
        repeat (int'($urandom_range(0, 3))) @(negedge clk);
        chk(slp == 1 && moh == exp_oh(v[4:2]), "R5 holds asleep", moh, exp_oh(v[4:2]));
        if ($urandom_range(0, 3) == 0) rst_wake(v, int'($urandom_range(0, 2)));
        else irq_wake(v, 1'($urandom));
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule